// File: doc/BRIEF.md
# DTMF Single-Group Tone Synthesizer

This block produces a stream of signed 8-bit sine samples at one of the four tone frequencies of either the high or the low DTMF group. A group select picks the table of periods, and a 2-bit code picks the tone within it. A prescaler reduces the system clock to a common 480 kHz enable tick. The supported system clocks are 480 kHz and its 2×, 4× and 8× multiples, named by a 2-bit range code. Each tick advances a position counter whose full period is a whole number of ticks, so the design frequency is exactly 480 kHz divided by that count. It misses the nominal tone by at most 0.37 %, which happens at the 941 Hz code.

A fractional step adds 64 per tick and wraps at the period count. It walks a 64-point signed sine table, so the table index is always floor(64·t/N), where t is the tick position within a period of N ticks. Each tick yields one registered sample and a one-cycle valid strobe. A new tone or group request is adopted only when the period wraps to phase zero, which is a zero crossing of the waveform. Dropping the enable silences the output and rewinds the phase. Level scaling and conversion to analogue belong to the next stage.

Top module: `dtmf_tone_synth`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tone_sample` is 0 and `tone_vld` is 0.
- R2: While enabled, `tone_vld` pulses once every 1, 2, 4 or 8 system clock cycles for `clk_range` codes 0, 1, 2 and 3. The first pulse comes that many cycles after the enable rises.
- R3: With `grp_hi`=1, `tone_code` 0/1/2/3 gives a period of 396/360/324/294 ticks (1212.1/1333.3/1481.5/1632.7 Hz for nominal 1209/1336/1477/1633 Hz).
- R4: With `grp_hi`=0, `tone_code` 0/1/2/3 gives a period of 688/624/564/512 ticks (697.7/769.2/851.1/937.5 Hz for nominal 697/770/852/941 Hz).
- R5: The sample carried by the k-th strobe after enable (k counted from 0) is round(127·sin(2π·i/64)), with i = floor(64·t/N) and t = k mod N. Rounding is half away from zero.
- R6: While `tone_en` is 0, the output is 0 with no strobe. The next enable restarts the waveform at t=0.
- R7: A change of `tone_code` or `grp_hi` while enabled takes effect only at the strobe after the one with t=N−1. The old period is completed first.
- R8: The sample is never −128; the waveform is symmetric about zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tone_en | input | 1 | Enables tone generation; low clears phase and output |
| clk_range | input | 2 | System clock multiple of 480 kHz: 0=1×, 1=2×, 2=4×, 3=8× |
| tone_code | input | 2 | Tone select within the group |
| grp_hi | input | 1 | 1 selects the high group periods, 0 the low group |
| tone_sample | output | 8 | Signed sine sample |
| tone_vld | output | 1 | One-cycle strobe marking a new sample |

## Verification
Two events can land on the same tick: the period wrap and a pending tone request. If the wrap and the request change coincide, the old period's last sample and the new period's count are both decided in that cycle. The bench changes the tone code in the middle of a period and lets a full reference model run across the wrap. Every sample must match the old count up to t=N−1 and the new count from t=0 on. A disable that falls between ticks is also provoked, and the bench then checks that the output is silent and the waveform restarts at t=0.

// File: rtl/dtmf_tone_pkg.sv
package dtmf_tone_pkg;

  localparam int SAMPLE_W = 8;
  localparam int IDX_W    = 6;
  localparam int TABLE_N  = 1 << IDX_W;

  // Ticks per full period at the 480 kHz tick rate.
  function automatic logic [9:0] period_ticks(input logic hi, input logic [1:0] code);
    logic [9:0] n;
    if (hi) begin
      case (code)
        2'd0: n = 10'd396;
        2'd1: n = 10'd360;
        2'd2: n = 10'd324;
        default: n = 10'd294;
      endcase
    end else begin
      case (code)
        2'd0: n = 10'd688;
        2'd1: n = 10'd624;
        2'd2: n = 10'd564;
        default: n = 10'd512;
      endcase
    end
    return n;
  endfunction

  // Quarter wave magnitude, 127*sin(k*pi/32) rounded, k = 0..16.
  function automatic logic [6:0] quarter_mag(input logic [4:0] k);
    logic [6:0] m;
    case (k)
      5'd0:  m = 7'd0;
      5'd1:  m = 7'd12;
      5'd2:  m = 7'd25;
      5'd3:  m = 7'd37;
      5'd4:  m = 7'd49;
      5'd5:  m = 7'd60;
      5'd6:  m = 7'd71;
      5'd7:  m = 7'd81;
      5'd8:  m = 7'd90;
      5'd9:  m = 7'd98;
      5'd10: m = 7'd106;
      5'd11: m = 7'd112;
      5'd12: m = 7'd117;
      5'd13: m = 7'd122;
      5'd14: m = 7'd125;
      5'd15: m = 7'd126;
      default: m = 7'd127;
    endcase
    return m;
  endfunction

  // Full-wave sample from a 64-point index using quadrant folding.
  function automatic logic signed [SAMPLE_W-1:0] sine_at(input logic [IDX_W-1:0] idx);
    logic [4:0] k;
    logic [6:0] mag;
    case (idx[5:4])
      2'd0: k = {1'b0, idx[3:0]};
      2'd1: k = 5'(6'd32 - idx);
      2'd2: k = {1'b0, idx[3:0]};
      default: k = 5'(7'd64 - {1'b0, idx});
    endcase
    mag = quarter_mag(k);
    return idx[5] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  endfunction

endpackage

// File: rtl/dtmf_tick_prescaler.sv
module dtmf_tick_prescaler #(
  parameter int RANGE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [RANGE_W-1:0] range_code,
  output logic               tick
);
  localparam int CNT_W = (1 << RANGE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = CNT_W'((1 << range_code) - 1);
  assign tick     = run && (cnt_q >= last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dtmf_phase_walker.sv
module dtmf_phase_walker #(
  parameter int PHASE_W = 10,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic [PHASE_W-1:0] req_period,
  output logic [PHASE_W-1:0] phase_q,
  output logic [PHASE_W-1:0] period_q,
  output logic [IDX_W-1:0]   idx_q,
  output logic               wrap
);
  localparam logic [PHASE_W-1:0] STEP = PHASE_W'(1 << IDX_W);

  logic [PHASE_W-1:0] frac_q;
  logic [PHASE_W-1:0] frac_sum;
  logic               carry;

  assign wrap     = tick && (phase_q == period_q - 1'b1);
  assign frac_sum = frac_q + STEP;
  assign carry    = frac_sum >= period_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      frac_q   <= '0;
      idx_q    <= '0;
      period_q <= PHASE_W'(1);
    end else if (!run) begin
      phase_q  <= '0;
      frac_q   <= '0;
      idx_q    <= '0;
      period_q <= req_period;
    end else if (wrap) begin
      phase_q  <= '0;
      frac_q   <= '0;
      idx_q    <= '0;
      period_q <= req_period;
    end else if (tick) begin
      phase_q <= phase_q + 1'b1;
      frac_q  <= carry ? frac_sum - period_q : frac_sum;
      idx_q   <= idx_q + IDX_W'(carry);
    end
  end
endmodule

// File: rtl/dtmf_sine_stage.sv
module dtmf_sine_stage (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                run,
  input  logic                                tick,
  input  logic [dtmf_tone_pkg::IDX_W-1:0]     idx,
  output logic signed [dtmf_tone_pkg::SAMPLE_W-1:0] sample_q,
  output logic                                vld_q
);
  import dtmf_tone_pkg::*;

  logic signed [SAMPLE_W-1:0] table_val;
  assign table_val = sine_at(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      vld_q    <= 1'b0;
    end else if (!run) begin
      sample_q <= '0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= tick;
      if (tick) sample_q <= table_val;
    end
  end
endmodule

// File: rtl/dtmf_tone_synth.sv
module dtmf_tone_synth #(
  parameter int PHASE_W = 10,
  parameter int RANGE_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tone_en,
  input  logic [RANGE_W-1:0]  clk_range,
  input  logic [1:0]          tone_code,
  input  logic                grp_hi,
  output logic signed [7:0]   tone_sample,
  output logic                tone_vld
);
  import dtmf_tone_pkg::*;

  logic               tick;
  logic               wrap;
  logic [PHASE_W-1:0] req_period;
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] period_q;
  logic [IDX_W-1:0]   idx_q;

  assign req_period = PHASE_W'(period_ticks(grp_hi, tone_code));

  dtmf_tick_prescaler #(.RANGE_W(RANGE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(tone_en),
    .range_code(clk_range), .tick(tick)
  );

  dtmf_phase_walker #(.PHASE_W(PHASE_W), .IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .run(tone_en), .tick(tick),
    .req_period(req_period), .phase_q(phase_q), .period_q(period_q),
    .idx_q(idx_q), .wrap(wrap)
  );

  dtmf_sine_stage u_sine (
    .clk(clk), .rst_n(rst_n), .run(tone_en), .tick(tick),
    .idx(idx_q), .sample_q(tone_sample), .vld_q(tone_vld)
  );
endmodule

// File: rtl/dtmf_tone_synth_chk.sv
module dtmf_tone_synth_chk #(
  parameter int PHASE_W = 10,
  parameter int RANGE_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tone_en,
  input logic [RANGE_W-1:0] clk_range,
  input logic signed [7:0]  tone_sample,
  input logic               tone_vld,
  input logic               tick,
  input logic               wrap,
  input logic [PHASE_W-1:0] phase_q,
  input logic [PHASE_W-1:0] period_q
);
  // R6
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_en |=> (tone_sample == 0) && !tone_vld);

  // R2
  strobe_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tone_en && tick |=> tone_vld);

  // R2
  full_rate_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tone_en && clk_range == '0 |-> tick);

  // R7
  period_moves_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tone_en && $past(tone_en) && (period_q != $past(period_q)) |-> phase_q == '0 && $past(wrap));

  // R3
  phase_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < period_q);

  // R8
  no_neg_full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tone_sample != -8'sd128);
endmodule

bind dtmf_tone_synth dtmf_tone_synth_chk #(.PHASE_W(PHASE_W), .RANGE_W(RANGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .clk_range(clk_range),
  .tone_sample(tone_sample), .tone_vld(tone_vld), .tick(tick), .wrap(wrap),
  .phase_q(phase_q), .period_q(period_q)
);

// File: tb/dtmf_tone_synth_bench.sv
module dtmf_tone_synth_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tone_en = 1'b0;
  logic [1:0] clk_range = 2'd0;
  logic [1:0] tone_code = 2'd0;
  logic grp_hi = 1'b1;
  logic signed [7:0] tone_sample;
  logic tone_vld;

  int checks = 0;
  int errors = 0;
  int m_t = 0;
  int m_n = 1;
  int gap = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dtmf_tone_synth u_dtmf_tone_synth (
    .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .clk_range(clk_range),
    .tone_code(tone_code), .grp_hi(grp_hi),
    .tone_sample(tone_sample), .tone_vld(tone_vld)
  );

  function automatic int ref_period(input bit hi, input int code);
    if (hi) return (code == 0) ? 396 : (code == 1) ? 360 : (code == 2) ? 324 : 294;
    return (code == 0) ? 688 : (code == 1) ? 624 : (code == 2) ? 564 : 512;
  endfunction

  function automatic int ref_sample(input int t, input int n);
    int i;
    real x;
    i = (t * 64) / n;
    x = 127.0 * $sin(2.0 * 3.14159265358979 * i / 64.0);
    if (x >= 0.0) return int'($floor(x + 0.5));
    return -int'($floor(-x + 0.5));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_tone(input int rng, input bit hi, input int code);
    @(negedge clk);
    tone_en = 1'b0;
    clk_range = 2'(rng);
    grp_hi = hi;
    tone_code = 2'(code);
    @(negedge clk);
    @(negedge clk);
    tone_en = 1'b1;
    m_t = 0;
    m_n = ref_period(hi, code);
    gap = 0;
  endtask

  // Consumes n strobes and checks spacing and values against the model.
  task automatic run_ticks(input int n, input string req);
    int got = 0;
    while (got < n) begin
      @(negedge clk);
      gap++;
      if (tone_vld) begin
        chk(gap == (1 << clk_range), "R2", gap, 1 << clk_range);
        chk(tone_sample == ref_sample(m_t, m_n), req, tone_sample, ref_sample(m_t, m_n));
        chk(tone_sample != -128, "R8", tone_sample, 0);
        if (m_t == m_n - 1) begin
          m_t = 0;
          m_n = ref_period(grp_hi, tone_code);
        end else m_t++;
        gap = 0;
        got++;
      end
    end
  endtask

  task automatic t_reset();
    #5;
    chk(tone_sample == 0, "R1", tone_sample, 0);
    chk(tone_vld == 0, "R1", tone_vld, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tone_sample == 0, "R1", tone_sample, 0);
    chk(tone_vld == 0, "R1", tone_vld, 0);
  endtask

  task automatic t_high_group();
    for (int c = 0; c < 4; c++) begin
      start_tone(0, 1'b1, c);
      run_ticks(ref_period(1'b1, c) + 3, "R3 R5");
    end
  endtask

  task automatic t_low_group();
    for (int c = 0; c < 4; c++) begin
      start_tone(0, 1'b0, c);
      run_ticks(ref_period(1'b0, c) + 3, "R4 R5");
    end
  endtask

  task automatic t_prescale();
    for (int r = 1; r < 4; r++) begin
      start_tone(r, 1'b1, 3);
      run_ticks(40, "R2 R5");
    end
  endtask

  task automatic t_disable();
    start_tone(1, 1'b0, 2);
    run_ticks(77, "R6");
    tone_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(tone_sample == 0, "R6", tone_sample, 0);
      chk(tone_vld == 0, "R6", tone_vld, 0);
    end
    tone_en = 1'b1;
    m_t = 0;
    m_n = ref_period(1'b0, 2);
    gap = 0;
    run_ticks(30, "R6");
  endtask

  task automatic t_switch();
    start_tone(0, 1'b1, 0);
    run_ticks(100, "R7");
    tone_code = 2'd3;
    run_ticks(600, "R7");
    grp_hi = 1'b0;
    run_ticks(400, "R7");
  endtask

  initial begin
    t_reset();
    t_high_group();
    t_low_group();
    t_prescale();
    t_disable();
    t_switch();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule